// File: doc/BRIEF.md
# Single-Wire Bus Transaction Sequencer

This block runs one complete transaction on a single-wire, open-drain bus with a pull-up, the kind used to talk to a battery monitor. The host sets up a 7-bit register address, a write flag and, for writes, one data byte. It then pulses a request. The sequencer pulls the line low for a timed break and releases it for a recovery gap. It then hands the command byte to a bit-level transmitter. After that it either sends the data byte on the same transmitter or waits for the slave's first low edge and starts a bit-level receiver to collect one byte.

The bit cells themselves are produced by the transmitter and decoded by the receiver. Both sit outside this block and are reached through start and done handshakes. Every state change happens on a periodic sample tick. The time per tick is a parameter, and each timing constant is given in microseconds and turned into a tick count. Completion is visible as the completed-transaction counter catching up with the request counter. This happens whether the transaction succeeded or failed, and an error code and the read byte are reported alongside.

Top module: `swb_txn_seq`

## Requirements
- R1: After reset, busy, line_low, tx_start and rx_start are 0, req_count and done_count are 0, and rd_data and err_code are 0.
- R2: busy is 1 exactly when req_count differs from done_count. A req pulse while not busy increments req_count (modulo 2^CNT_W) and captures the command byte {cmd_wr, cmd_addr} with cmd_wr in bit 7, plus cmd_wdata. A req pulse while busy leaves req_count and the captured bytes unchanged.
- R3: On the first tick seen while busy in the idle state, line_low rises at that clock edge. It stays high for exactly BREAK_US/SAMPLE_PERIOD_US ticks.
- R4: After the break, the line is released for RECOV_US/SAMPLE_PERIOD_US ticks. Then tx_start pulses for one clock with tx_byte equal to the command byte; bit 7 = 1 means write and bit 7 = 0 means read.
- R5: tx_done and rx_done pulses may arrive on any clock. They are remembered and acted on only at the next tick, and no state change occurs on a clock without tick.
- R6: Write path. WR_GAP_US/SAMPLE_PERIOD_US ticks after the command byte's completion is acted on, tx_start pulses with tx_byte = the captured data byte. After that byte completes, the same gap again elapses and the transaction finishes with err_code 0.
- R7: Read path. After the command byte completes, the line is sampled on each tick. The first tick with line_in low pulses rx_start. If no low is seen within RX_WAIT_US/SAMPLE_PERIOD_US ticks, the transaction finishes with err_code 1.
- R8: On a read, the receiver's rx_byte and rx_err, captured at rx_done, appear on rd_data and err_code when the transaction finishes.
- R9: At every finish, successful or failed, done_count takes the value of req_count, so busy falls. done_count changes at no other time.
- R10: line_low is 0 at all times outside the break, so the line idles undriven and pulled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample tick, one clock wide |
| req | input | 1 | Request pulse |
| cmd_addr | input | 7 | Register address |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 8 | Byte to write |
| line_in | input | 1 | Sampled bus level |
| line_low | output | 1 | 1 = pull the bus low (break) |
| tx_start | output | 1 | Start the bit transmitter (one clock) |
| tx_byte | output | 8 | Byte for the transmitter |
| tx_done | input | 1 | Transmitter finished pulse |
| rx_start | output | 1 | Start the bit receiver (one clock) |
| rx_done | input | 1 | Receiver finished pulse |
| rx_byte | input | 8 | Byte from the receiver |
| rx_err | input | 2 | Receiver error code (0 = good) |
| busy | output | 1 | Transaction pending |
| req_count | output | CNT_W | Request counter |
| done_count | output | CNT_W | Completed-transaction counter |
| rd_data | output | 8 | Last read byte |
| err_code | output | 2 | 0 ok, 1 no response, others passed from receiver |

## Verification
A wrong sequencer state shows up at the ports within one tick. A break that is too short or too long changes the clock on which line_low falls. A wrong path choice sends tx_start where rx_start was due, or the reverse. A lost done flag leaves busy high until the bench's watchdog fires. Because a cycle-accurate reference model is compared on every clock, even an off-by-one in a tick count is reported on the exact clock where it first appears.

// File: rtl/swb_pkg.sv
// Shared types and helpers for the single-wire transaction sequencer.
// Assumes all timing values are positive microsecond counts.
package swb_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_BREAK, S_RECOV, S_CMD, S_GAP, S_DATA, S_TAIL, S_WAITRX, S_RX
    } seq_state_t;

    // Convert a duration in microseconds into sample ticks, never below one.
    function automatic int us_to_ticks(input int us, input int per_us);
        int t;
        t = us / per_us;
        return (t < 1) ? 1 : t;
    endfunction

endpackage

// File: rtl/swb_tick_timer.sv
// Loadable down-counter clocked by the sample tick.
// Assumes load wins over counting; the counter holds at zero.
module swb_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    // Count down one per tick, or take a new length.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/swb_req_track.sv
// Request and completion counters; busy while they differ.
// Assumes finish is raised only while busy.
module swb_req_track #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             finish,
    output logic [CNT_W-1:0] req_cnt,
    output logic [CNT_W-1:0] done_cnt,
    output logic             busy,
    output logic             accept
);
    assign busy   = (req_cnt != done_cnt);
    assign accept = req && !busy;

    // Bump the request counter on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_cnt <= '0;
        else if (accept) req_cnt <= req_cnt + 1'b1;
    end

    // Catch up to the request counter when a transaction ends.
    always_ff @(posedge clk) begin
        if (!rst_n)      done_cnt <= '0;
        else if (finish) done_cnt <= req_cnt;
    end

    assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> (req_cnt == $past(req_cnt)));
    assert_done_catchup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(done_cnt) |-> (done_cnt == req_cnt));
endmodule

// File: rtl/swb_txn_seq.sv
// Single-wire bus transaction sequencer: break, recovery, command byte,
// then a data byte (write) or a handover to the receiver (read).
// Assumes external bit transmitter/receiver with one-clock start/done pulses.
module swb_txn_seq import swb_pkg::*; #(
    parameter int SAMPLE_PERIOD_US = 10,
    parameter int BREAK_US         = 250,
    parameter int RECOV_US         = 60,
    parameter int WR_GAP_US        = 300,
    parameter int RX_WAIT_US       = 2500,
    parameter int CNT_W            = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             req,
    input  logic [6:0]       cmd_addr,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_wdata,
    input  logic             line_in,
    output logic             line_low,
    output logic             tx_start,
    output logic [7:0]       tx_byte,
    input  logic             tx_done,
    output logic             rx_start,
    input  logic             rx_done,
    input  logic [7:0]       rx_byte,
    input  logic [1:0]       rx_err,
    output logic             busy,
    output logic [CNT_W-1:0] req_count,
    output logic [CNT_W-1:0] done_count,
    output logic [7:0]       rd_data,
    output logic [1:0]       err_code
);
    localparam int T_BRK  = us_to_ticks(BREAK_US,   SAMPLE_PERIOD_US);
    localparam int T_REC  = us_to_ticks(RECOV_US,   SAMPLE_PERIOD_US);
    localparam int T_GAP  = us_to_ticks(WR_GAP_US,  SAMPLE_PERIOD_US);
    localparam int T_RXW  = us_to_ticks(RX_WAIT_US, SAMPLE_PERIOD_US);
    localparam int T_MAX  = (T_RXW > T_GAP) ? ((T_RXW > T_BRK) ? T_RXW : T_BRK)
                                            : ((T_GAP > T_BRK) ? T_GAP : T_BRK);
    localparam int TW     = $clog2(T_MAX + 1);

    seq_state_t     state, nxt;
    logic           accept, fin, tmr_last, ld;
    logic [TW-1:0]  ldv;
    logic [7:0]     cmd_q, wdat_q, rx_q, go_byte;
    logic [1:0]     rxe_q, fin_err;
    logic           tx_seen, rx_seen, go_tx, go_rx, brk_set, brk_clr, fin_rd;

    swb_req_track #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .req(req), .finish(fin),
        .req_cnt(req_count), .done_cnt(done_count), .busy(busy), .accept(accept)
    );

    swb_tick_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(ld), .load_val(ldv),
        .last(tmr_last)
    );

    // Next-state and action decode; only a tick can move the sequence.
    always_comb begin
        nxt = state; ld = 1'b0; ldv = '0; fin = 1'b0; fin_err = 2'd0;
        fin_rd = 1'b0; go_tx = 1'b0; go_byte = cmd_q; go_rx = 1'b0;
        brk_set = 1'b0; brk_clr = 1'b0;
        if (tick) begin
            unique case (state)
                S_IDLE:   if (busy) begin
                              nxt = S_BREAK; ld = 1'b1; ldv = TW'(T_BRK); brk_set = 1'b1;
                          end
                S_BREAK:  if (tmr_last) begin
                              nxt = S_RECOV; ld = 1'b1; ldv = TW'(T_REC); brk_clr = 1'b1;
                          end
                S_RECOV:  if (tmr_last) begin
                              nxt = S_CMD; go_tx = 1'b1; go_byte = cmd_q;
                          end
                S_CMD:    if (tx_seen) begin
                              ld = 1'b1;
                              if (cmd_q[7]) begin nxt = S_GAP;    ldv = TW'(T_GAP); end
                              else          begin nxt = S_WAITRX; ldv = TW'(T_RXW); end
                          end
                S_GAP:    if (tmr_last) begin
                              nxt = S_DATA; go_tx = 1'b1; go_byte = wdat_q;
                          end
                S_DATA:   if (tx_seen) begin
                              nxt = S_TAIL; ld = 1'b1; ldv = TW'(T_GAP);
                          end
                S_TAIL:   if (tmr_last) begin
                              nxt = S_IDLE; fin = 1'b1; fin_err = 2'd0;
                          end
                S_WAITRX: if (!line_in) begin
                              nxt = S_RX; go_rx = 1'b1;
                          end else if (tmr_last) begin
                              nxt = S_IDLE; fin = 1'b1; fin_err = 2'd1;
                          end
                S_RX:     if (rx_seen) begin
                              nxt = S_IDLE; fin = 1'b1; fin_err = rxe_q; fin_rd = 1'b1;
                          end
                default:  nxt = S_IDLE;
            endcase
        end
    end

    // Sequencer state, line drive and handshake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; line_low <= 1'b0; tx_start <= 1'b0; tx_byte <= '0;
            rx_start <= 1'b0; rd_data <= '0; err_code <= '0;
        end else begin
            state    <= nxt;
            tx_start <= go_tx;
            rx_start <= go_rx;
            if (go_tx)        tx_byte  <= go_byte;
            if (brk_set)      line_low <= 1'b1;
            else if (brk_clr) line_low <= 1'b0;
            if (fin)          err_code <= fin_err;
            if (fin_rd)       rd_data  <= rx_q;
        end
    end

    // Remember done pulses until the next tick consumes them.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != state) begin
            tx_seen <= 1'b0; rx_seen <= 1'b0;
        end else begin
            if (tx_done) tx_seen <= 1'b1;
            if (rx_done) rx_seen <= 1'b1;
        end
    end

    // Capture the receiver result with its done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       begin rx_q <= '0; rxe_q <= '0; end
        else if (rx_done) begin rx_q <= rx_byte; rxe_q <= rx_err; end
    end

    // Take the command and data bytes when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      begin cmd_q <= '0; wdat_q <= '0; end
        else if (accept) begin cmd_q <= {cmd_wr, cmd_addr}; wdat_q <= cmd_wdata; end
    end

    assert_active_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> busy);
    assert_drive_in_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_low |-> (state == S_BREAK));
    assert_tx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !rx_start);
    assert_move_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));
    assert_start_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start && rx_start));
endmodule

// File: tb/sim_swb_txn_seq.sv
`timescale 1ns/1ps
module sim_swb_txn_seq;
    localparam int TDIV = 3;          // clocks per sample tick
    localparam int TB = 25, TR = 6, TG = 30, TWX = 250;
    localparam int TXLAT = 20, RXLAT = 15;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, req = 1'b0;
    logic [6:0] cmd_addr = '0; logic cmd_wr = 1'b0; logic [7:0] cmd_wdata = '0;
    logic line_low, tx_start, rx_start, busy;
    logic [7:0] tx_byte, rd_data; logic [1:0] err_code;
    logic tx_done = 1'b0, rx_done = 1'b0, slave_low = 1'b0;
    logic [7:0] rx_byte = '0; logic [1:0] rx_err = '0;
    logic [3:0] req_count, done_count;
    wire line_in = !(line_low || slave_low);

    int n_chk = 0, n_bad = 0;
    logic [7:0] sent[$];
    int tx_cnt = 0, rx_cnt = 0, tdiv = 0, brk_run = 0, tx_done_cnt = 0;
    logic [7:0] rx_val = '0; logic [1:0] rx_errv = '0;
    bit started = 0, tick_at_edge = 0;

    // reference model state
    int ms = 0, rem = 0, ns; bit ld, last, bz;
    int lv, m_req = 0, m_done = 0;
    bit m_low = 0, m_txs = 0, m_rxs = 0, m_txseen = 0, m_rxseen = 0;
    logic [7:0] m_txb = 0, m_cmd = 0, m_wd = 0, m_rd = 0, m_rxq = 0;
    logic [1:0] m_err = 0, m_rxeq = 0;

    swb_txn_seq u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .cmd_addr(cmd_addr),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .line_in(line_in),
        .line_low(line_low), .tx_start(tx_start), .tx_byte(tx_byte),
        .tx_done(tx_done), .rx_start(rx_start), .rx_done(rx_done),
        .rx_byte(rx_byte), .rx_err(rx_err), .busy(busy), .req_count(req_count),
        .done_count(done_count), .rd_data(rd_data), .err_code(err_code)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every clock edge.
    always @(posedge clk) begin
        tick_at_edge = tick;
        started = 1;
        if (!rst_n) begin
            ms = 0; rem = 0; m_req = 0; m_done = 0; m_low = 0; m_txs = 0; m_rxs = 0;
            m_txseen = 0; m_rxseen = 0; m_txb = 0; m_cmd = 0; m_wd = 0; m_rd = 0;
            m_rxq = 0; m_err = 0; m_rxeq = 0;
        end else begin
            bz = (m_req != m_done); ns = ms; ld = 0; lv = 0; last = (rem == 1);
            m_txs = 0; m_rxs = 0;
            if (tick) case (ms)
                0: if (bz) begin ns = 1; ld = 1; lv = TB; m_low = 1; end
                1: if (last) begin ns = 2; ld = 1; lv = TR; m_low = 0; end
                2: if (last) begin ns = 3; m_txs = 1; m_txb = m_cmd; end
                3: if (m_txseen) begin ld = 1; if (m_cmd[7]) begin ns = 4; lv = TG; end
                                              else begin ns = 7; lv = TWX; end end
                4: if (last) begin ns = 5; m_txs = 1; m_txb = m_wd; end
                5: if (m_txseen) begin ns = 6; ld = 1; lv = TG; end
                6: if (last) begin ns = 0; m_err = 0; m_done = m_req; end
                7: if (!(!(m_low || slave_low)) == 1'b1) begin ns = 8; m_rxs = 1; end
                   else if (last) begin ns = 0; m_err = 1; m_done = m_req; end
                8: if (m_rxseen) begin ns = 0; m_rd = m_rxq; m_err = m_rxeq; m_done = m_req; end
                default: ns = 0;
            endcase
            if (ld) rem = lv; else if (tick && rem > 0) rem--;
            if (ns != ms) begin m_txseen = 0; m_rxseen = 0; end
            else begin
                if (tx_done) m_txseen = 1;
                if (rx_done) m_rxseen = 1;
            end
            if (rx_done) begin m_rxq = rx_byte; m_rxeq = rx_err; end
            if (req && !bz) begin m_req = (m_req + 1) % 16; m_cmd = {cmd_wr, cmd_addr}; m_wd = cmd_wdata; end
            ms = ns;
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) if (started) begin
        chk(line_low == m_low, "R3 line_low", line_low, m_low);
        chk(tx_start == m_txs, "R4 tx_start", tx_start, m_txs);
        chk(tx_byte == m_txb, "R4 tx_byte", tx_byte, m_txb);
        chk(rx_start == m_rxs, "R7 rx_start", rx_start, m_rxs);
        chk(busy == (m_req != m_done), "R2 busy", busy, m_req != m_done);
        chk(req_count == m_req[3:0], "R2 req_count", req_count, m_req);
        chk(done_count == m_done[3:0], "R9 done_count", done_count, m_done);
        chk(rd_data == m_rd, "R8 rd_data", rd_data, m_rd);
        chk(err_code == m_err, "R8 err_code", err_code, m_err);
        if (tx_start) chk(tick_at_edge, "R5 start on tick", tick_at_edge, 1);
    end

    // Tick generator and bit-level transmitter/receiver stand-ins.
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TDIV;
        tick = (tdiv == 0);
        tx_done = 0; rx_done = 0;
        if (tx_start) begin tx_cnt = TXLAT; sent.push_back(tx_byte); end
        else if (tx_cnt > 0) begin tx_cnt--; if (tx_cnt == 0) begin tx_done = 1; tx_done_cnt++; end end
        if (rx_start) rx_cnt = RXLAT;
        else if (rx_cnt > 0) begin
            rx_cnt--;
            if (rx_cnt == 0) begin rx_done = 1; rx_byte = rx_val; rx_err = rx_errv; end
        end
        if (line_low) brk_run++;
        else if (brk_run > 0) begin
            chk(brk_run == TB * TDIV, "R3 break length", brk_run, TB * TDIV);
            brk_run = 0;
        end
    end

    task automatic issue(input logic w, input logic [6:0] a, input logic [7:0] d);
        @(negedge clk); cmd_wr = w; cmd_addr = a; cmd_wdata = d; req = 1;
        @(negedge clk); req = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        #1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        int s0 = sent.size();
        logic [3:0] rc;
        issue(1'b1, a, d);
        repeat (10) @(negedge clk);
        rc = req_count;
        issue(1'b0, 7'h7F, 8'h00);             // ignored while busy
        chk(req_count == rc, "R2 ignored req", req_count, rc);
        wait_idle();
        chk(sent.size() == s0 + 2, "R6 byte count", sent.size() - s0, 2);
        if (sent.size() == s0 + 2) begin
            chk(sent[s0] == {1'b1, a}, "R4 write command", sent[s0], {1'b1, a});
            chk(sent[s0+1] == d, "R6 data byte", sent[s0+1], d);
        end
        chk(err_code == 0, "R6 write err", err_code, 0);
        chk(done_count == req_count, "R9 write finish", done_count, req_count);
        chk(line_low == 0, "R10 idle line", line_low, 0);
    endtask

    task automatic do_read(input logic [6:0] a, input bit respond,
                           input logic [7:0] rb, input logic [1:0] re);
        int s0 = sent.size(); int d0 = tx_done_cnt;
        rx_val = rb; rx_errv = re;
        issue(1'b0, a, 8'h00);
        if (respond) begin
            while (tx_done_cnt == d0) @(negedge clk);
            repeat (60) @(negedge clk);
            slave_low = 1;
            repeat (30) @(negedge clk);
            slave_low = 0;
        end
        wait_idle();
        chk(sent.size() == s0 + 1, "R7 one byte sent", sent.size() - s0, 1);
        if (sent.size() > s0)
            chk(sent[s0] == {1'b0, a}, "R4 read command", sent[s0], {1'b0, a});
        if (respond) begin
            chk(rd_data == rb, "R8 read byte", rd_data, rb);
            chk(err_code == re, "R8 read err", err_code, re);
        end else
            chk(err_code == 2'd1, "R7 timeout err", err_code, 1);
        chk(done_count == req_count, "R9 read finish", done_count, req_count);
        chk(line_low == 0, "R10 idle line", line_low, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !line_low && !tx_start && !rx_start, "R1 reset outputs", busy, 0);
        chk(req_count == 0 && done_count == 0, "R1 reset counters", req_count, 0);
        chk(rd_data == 0 && err_code == 0, "R1 reset data", rd_data, 0);
        do_write(7'h12, 8'hA5);
        do_read(7'h05, 1, 8'h3C, 2'd0);
        do_read(7'h40, 1, 8'hC3, 2'd2);
        do_read(7'h33, 0, 8'h00, 2'd0);
        do_write(7'h7F, 8'h00);
        do_read(7'h00, 1, 8'hFF, 2'd3);
        repeat (20) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule